// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Bus Master

This block drives a serial EEPROM over chip select, serial clock and serial data out, and samples the memory's serial data line. A client hands it one operation at a time through a valid/ready command port: read a run of words, write a word, erase a word, erase the whole array, fill the whole array with one word, enable programming or disable programming. The block builds the frame from a start bit, a two-bit opcode and an address field sent most significant bit first. A write-type frame also carries a data word. Read words come back through a valid/ready stream. A one-cycle `done_o` pulse marks the end of every operation.

After a frame that starts a programming cycle, the block drops chip select on an exact clock count. It then holds chip select low for a guard interval and raises it again. It polls the data line until the memory reports ready, or until a cycle budget runs out. When `AUTO_LOCK` is set, a disable frame follows every successful programming operation. The serial clock half period, the address and word widths, the guard interval and the poll budget are all parameters.

Top module: `mw_host`

## Requirements
- R1: A frame starts with chip select rising while the serial clock is low, followed by a 1 start bit, two opcode bits and ADDR_W address bits, most significant bit first. The opcode is 10 for read (`cmd_op_i`=0), 01 for write (1) and 11 for erase (2). All other operations use opcode 00, and the two top address bits then select the function: 10 erase-all (3), 01 write-all (4), 11 enable (5), and 00 disable (6 and 7). The remaining address bits of those frames are 0. Serial data changes only while the serial clock is low.
- R2: The serial clock is high for CLK_DIV cycles and low for at least CLK_DIV cycles. It toggles only while chip select is high.
- R3: A read samples the bit clocked out with the last address bit as a dummy and discards it. It then assembles `cmd_len_i`+1 words MSB first from consecutive addresses, with no dummy bit between words, and rolls over from the top address to 0.
- R4: While a read word is offered and `rd_ready_i` is low, `rd_valid_o` stays high, `rd_data_o` stays stable and the serial clock stays low.
- R5: Write and write-all frames carry exactly 3+ADDR_W+WORD_W clock pulses. Erase, erase-all, enable and disable frames carry exactly 3+ADDR_W. Chip select falls on the falling clock edge of the final bit.
- R6: Chip select stays low for at least GAP_CYC cycles after every frame. After a programming frame it then rises with the clock idle, and `done_o` does not come before the memory drives ready (1) on its data line.
- R7: If ready is not seen within POLL_LIMIT cycles of polling, the operation ends with `err_o` high in the same cycle as `done_o`. Otherwise `err_o` stays low.
- R8: `cmd_ready_o` is high only while no operation is in flight. A command is taken when `cmd_valid_i` and `cmd_ready_o` are both high.
- R9: With AUTO_LOCK set, each successfully polled programming operation is followed by a disable frame before `done_o`. A later write that is not preceded by an enable leaves the memory unchanged.
- R10: Enable and disable frames involve no polling: one chip select pulse, then the guard interval, then `done_o`.
- R11: During and after reset, chip select and serial clock are low, `cmd_ready_o` is high, and `rd_valid_o` and `done_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cmd_valid_i | input | 1 | Command offered |
| cmd_ready_o | output | 1 | Block idle, command taken |
| cmd_op_i | input | 3 | Operation code (see R1) |
| cmd_addr_i | input | ADDR_W | Word address |
| cmd_wdata_i | input | WORD_W | Data for write and write-all |
| cmd_len_i | input | LEN_W | Read word count minus one |
| rd_valid_o | output | 1 | Read word offered |
| rd_ready_i | input | 1 | Read word taken |
| rd_data_o | output | WORD_W | Read word |
| done_o | output | 1 | One-cycle completion pulse |
| err_o | output | 1 | Poll timeout, coincident with done_o |
| mw_cs_o | output | 1 | Memory chip select |
| mw_sk_o | output | 1 | Memory serial clock |
| mw_di_o | output | 1 | Serial data to the memory |
| mw_do_i | input | 1 | Serial data from the memory |

## Verification
One bit takes 2*CLK_DIV cycles. The first rising clock edge comes CLK_DIV cycles after chip select rises, so an n-bit frame drops chip select 2*n*CLK_DIV cycles after the command is taken. The first read word is offered 2*(3+ADDR_W+WORD_W)*CLK_DIV cycles after the command, and each further word 2*WORD_W*CLK_DIV cycles after the previous handshake. `done_o` follows GAP_CYC cycles after the last chip select fall. A memory model in the bench sees every edge of the serial lines and counts clock pulses per frame, high-time lengths and chip select low intervals. The bench waits on the `done_o` and read handshakes rather than on fixed delays, samples outputs on the falling system clock edge, and compares model state and captured words once each operation has ended.

// File: rtl/mw_pkg.sv
`timescale 1ns/1ps
package mw_pkg;

  typedef enum logic [2:0] {
    OP_READ  = 3'd0,
    OP_WRITE = 3'd1,
    OP_ERASE = 3'd2,
    OP_ERAL  = 3'd3,
    OP_WRAL  = 3'd4,
    OP_WEN   = 3'd5,
    OP_WDS   = 3'd6
  } mw_op_e;

  typedef enum logic [2:0] {
    ST_IDLE, ST_SEND, ST_RECV, ST_HOLD, ST_GAP, ST_POLL
  } mw_st_e;

  typedef enum logic [1:0] {NX_POLL, NX_SEND, NX_DONE} mw_nx_e;

  function automatic logic [1:0] op_code(mw_op_e op);
    case (op)
      OP_READ:  return 2'b10;
      OP_WRITE: return 2'b01;
      OP_ERASE: return 2'b11;
      default:  return 2'b00;
    endcase
  endfunction

  // function select carried in the two top address bits of opcode-00 frames
  function automatic logic [1:0] sub_code(mw_op_e op);
    case (op)
      OP_ERAL: return 2'b10;
      OP_WRAL: return 2'b01;
      OP_WEN:  return 2'b11;
      default: return 2'b00;
    endcase
  endfunction

  function automatic logic uses_addr(mw_op_e op);
    return op inside {OP_READ, OP_WRITE, OP_ERASE};
  endfunction

  function automatic logic has_data(mw_op_e op);
    return op inside {OP_WRITE, OP_WRAL};
  endfunction

  function automatic logic is_prog(mw_op_e op);
    return op inside {OP_WRITE, OP_ERASE, OP_ERAL, OP_WRAL};
  endfunction

endpackage

// File: rtl/mw_tick.sv
`timescale 1ns/1ps
module mw_tick #(
  parameter int DIV = 4
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic run_i,
  output logic tick_o
);
  localparam int CW = (DIV > 1) ? $clog2(DIV) : 1;

  logic [CW-1:0] cnt_q;

  assign tick_o = run_i && (cnt_q == CW'(DIV - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)               cnt_q <= '0;
    else if (!run_i || tick_o) cnt_q <= '0;
    else                       cnt_q <= cnt_q + 1'b1;
  end

  generate
    if (DIV > 1) begin : g_gap_chk
      p_tick_gap_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        tick_o |=> !tick_o);
    end
  endgenerate

endmodule

// File: rtl/mw_shreg.sv
`timescale 1ns/1ps
module mw_shreg #(
  parameter int W = 8
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] par_i,
  input  logic         shift_i,
  input  logic         ser_i,
  output logic [W-1:0] q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      q_o <= '0;
    else if (load_i)  q_o <= par_i;
    else if (shift_i) q_o <= {q_o[W-2:0], ser_i};
  end
endmodule

// File: rtl/mw_host.sv
`timescale 1ns/1ps
module mw_host
  import mw_pkg::*;
#(
  parameter int ADDR_W     = 6,
  parameter int WORD_W     = 16,
  parameter int LEN_W      = 4,
  parameter int CLK_DIV    = 4,    // half serial period in clk_i cycles, >= 4 with the input sync
  parameter int GAP_CYC    = 8,
  parameter int POLL_LIMIT = 1024,
  parameter bit AUTO_LOCK  = 1'b1
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              cmd_valid_i,
  output logic              cmd_ready_o,
  input  logic [2:0]        cmd_op_i,
  input  logic [ADDR_W-1:0] cmd_addr_i,
  input  logic [WORD_W-1:0] cmd_wdata_i,
  input  logic [LEN_W-1:0]  cmd_len_i,
  output logic              rd_valid_o,
  input  logic              rd_ready_i,
  output logic [WORD_W-1:0] rd_data_o,
  output logic              done_o,
  output logic              err_o,
  output logic              mw_cs_o,
  output logic              mw_sk_o,
  output logic              mw_di_o,
  input  logic              mw_do_i
);
  localparam int HDR_W     = 3 + ADDR_W;
  localparam int FRM_W     = HDR_W + WORD_W;
  localparam int CNT_W     = $clog2(FRM_W + 1);
  localparam int WB_W      = $clog2(WORD_W + 1);
  localparam int GAP_W     = $clog2(GAP_CYC + 1);
  localparam int POLL_W    = $clog2(POLL_LIMIT + 1);
  localparam int SYNC_WAIT = 3;

  mw_st_e             state_q;
  mw_nx_e             nxt_q;
  mw_op_e             op_q, ld_op;
  logic [CNT_W-1:0]   bits_q;
  logic [WB_W-1:0]    wbits_q;
  logic [LEN_W-1:0]   words_q;
  logic [GAP_W-1:0]   gap_q;
  logic [POLL_W-1:0]  poll_q;
  logic               cs_q, sk_q, done_q, err_q;
  logic               q_m, q_s;
  logic               tick, accept, poll_ok, tx_load, tx_shift, rx_shift;
  logic [ADDR_W-1:0]  afield;
  logic [FRM_W-1:0]   ld_frame, tx_q;

  assign accept   = cmd_valid_i && (state_q == ST_IDLE);
  assign poll_ok  = (state_q == ST_POLL) && (poll_q >= POLL_W'(SYNC_WAIT)) && q_s;
  assign tx_load  = accept || (poll_ok && AUTO_LOCK);
  assign tx_shift = (state_q == ST_SEND) && tick && sk_q;
  assign rx_shift = (state_q == ST_RECV) && tick && sk_q;

  always_comb begin
    ld_op  = (state_q == ST_IDLE) ? mw_op_e'(cmd_op_i) : OP_WDS;
    afield = uses_addr(ld_op) ? cmd_addr_i : {sub_code(ld_op), {(ADDR_W-2){1'b0}}};
    ld_frame = {1'b1, op_code(ld_op), afield,
                has_data(ld_op) ? cmd_wdata_i : {WORD_W{1'b0}}};
  end

  mw_tick #(.DIV(CLK_DIV)) i_tick (
    .clk_i (clk_i), .rst_ni (rst_ni),
    .run_i ((state_q == ST_SEND) || (state_q == ST_RECV)),
    .tick_o(tick)
  );

  mw_shreg #(.W(FRM_W)) i_tx (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(tx_load), .par_i(ld_frame),
    .shift_i(tx_shift), .ser_i(1'b0), .q_o(tx_q)
  );

  mw_shreg #(.W(WORD_W)) i_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(1'b0), .par_i({WORD_W{1'b0}}),
    .shift_i(rx_shift), .ser_i(q_s), .q_o(rd_data_o)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      q_m <= 1'b0;
      q_s <= 1'b0;
    end else begin
      q_m <= mw_do_i;
      q_s <= q_m;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_IDLE;
      nxt_q   <= NX_DONE;
      op_q    <= OP_WDS;
      bits_q  <= '0;
      wbits_q <= '0;
      words_q <= '0;
      gap_q   <= '0;
      poll_q  <= '0;
      cs_q    <= 1'b0;
      sk_q    <= 1'b0;
      done_q  <= 1'b0;
      err_q   <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (state_q)
        ST_IDLE: if (accept) begin
          op_q    <= mw_op_e'(cmd_op_i);
          bits_q  <= CNT_W'(has_data(mw_op_e'(cmd_op_i)) ? FRM_W : HDR_W);
          words_q <= cmd_len_i;
          err_q   <= 1'b0;
          cs_q    <= 1'b1;
          state_q <= ST_SEND;
        end
        ST_SEND: if (tick) begin
          sk_q <= !sk_q;
          if (sk_q) begin
            if (bits_q == CNT_W'(1)) begin
              if (op_q == OP_READ) begin
                // the sample taken on this edge is the dummy bit, dropped
                wbits_q <= WB_W'(WORD_W);
                state_q <= ST_RECV;
              end else begin
                cs_q    <= 1'b0;
                nxt_q   <= is_prog(op_q) ? NX_POLL : NX_DONE;
                state_q <= ST_GAP;
              end
            end else begin
              bits_q <= bits_q - 1'b1;
            end
          end
        end
        ST_RECV: if (tick) begin
          sk_q <= !sk_q;
          if (sk_q) begin
            if (wbits_q == WB_W'(1)) state_q <= ST_HOLD;
            else                     wbits_q <= wbits_q - 1'b1;
          end
        end
        ST_HOLD: if (rd_ready_i) begin
          if (words_q == '0) begin
            cs_q    <= 1'b0;
            nxt_q   <= NX_DONE;
            state_q <= ST_GAP;
          end else begin
            words_q <= words_q - 1'b1;
            wbits_q <= WB_W'(WORD_W);
            state_q <= ST_RECV;
          end
        end
        ST_GAP: begin
          if (gap_q == GAP_W'(GAP_CYC - 1)) begin
            gap_q <= '0;
            case (nxt_q)
              NX_POLL: begin
                cs_q    <= 1'b1;
                poll_q  <= '0;
                state_q <= ST_POLL;
              end
              NX_SEND: begin
                cs_q    <= 1'b1;
                bits_q  <= CNT_W'(HDR_W);
                state_q <= ST_SEND;
              end
              default: begin
                done_q  <= 1'b1;
                state_q <= ST_IDLE;
              end
            endcase
          end else begin
            gap_q <= gap_q + 1'b1;
          end
        end
        ST_POLL: begin
          if (poll_ok) begin
            cs_q    <= 1'b0;
            state_q <= ST_GAP;
            if (AUTO_LOCK) begin
              op_q  <= OP_WDS;
              nxt_q <= NX_SEND;
            end else begin
              nxt_q <= NX_DONE;
            end
          end else if (poll_q == POLL_W'(POLL_LIMIT - 1)) begin
            err_q   <= 1'b1;
            cs_q    <= 1'b0;
            nxt_q   <= NX_DONE;
            state_q <= ST_GAP;
          end else begin
            poll_q <= poll_q + 1'b1;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign cmd_ready_o = (state_q == ST_IDLE);
  assign rd_valid_o  = (state_q == ST_HOLD);
  assign done_o      = done_q;
  assign err_o       = done_q && err_q;
  assign mw_cs_o     = cs_q;
  assign mw_sk_o     = sk_q;
  assign mw_di_o     = tx_q[FRM_W-1];

  p_cs_rise_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(mw_cs_o) |-> !mw_sk_o);
  p_d_stable_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mw_sk_o && $past(mw_sk_o) |-> $stable(mw_di_o));
  p_sk_sel_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mw_sk_o |-> mw_cs_o);
  p_rd_hold_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o && !rd_ready_i |=> rd_valid_o && $stable(rd_data_o) && !mw_sk_o);
  p_done_idle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !mw_cs_o && !mw_sk_o);
  p_err_done_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> done_o);
  p_ready_idle_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cmd_ready_o |-> !mw_cs_o && !rd_valid_o);

endmodule

// File: tb/test_mw_host.sv
`timescale 1ns/1ps
module test_mw_host;
  localparam int AW = 6, DW = 16, NW = 64, DIV = 4, GAP = 8, PLIM = 1024, BUSY = 200;

  logic clk = 1'b0, rst_n;
  logic cmd_valid, cmd_ready, rd_valid, rd_ready, done, err, cs, sk, di, mdo;
  logic [2:0] cmd_op;
  logic [AW-1:0] cmd_addr;
  logic [DW-1:0] cmd_wdata, rd_data;
  logic [3:0] cmd_len;

  always #2.5 clk = ~clk;

  mw_host i_mw_host (
    .clk_i(clk), .rst_ni(rst_n), .cmd_valid_i(cmd_valid), .cmd_ready_o(cmd_ready),
    .cmd_op_i(cmd_op), .cmd_addr_i(cmd_addr), .cmd_wdata_i(cmd_wdata), .cmd_len_i(cmd_len),
    .rd_valid_o(rd_valid), .rd_ready_i(rd_ready), .rd_data_o(rd_data),
    .done_o(done), .err_o(err), .mw_cs_o(cs), .mw_sk_o(sk), .mw_di_o(di), .mw_do_i(mdo)
  );

  int total = 0, bad = 0;
  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  // ---------------- memory model ----------------
  logic [DW-1:0] mem [NW];
  bit   m_sel_p, m_sk_p, m_start, m_rd, m_we, stuck;
  int   m_n, m_ridx, m_busy;
  logic [63:0] m_sr;
  logic [AW-1:0] m_raddr, ea;
  logic [1:0] eo;
  logic [DW-1:0] ed;
  logic m_q;
  int hi_len = 0, hi_min = 1000000, hi_max = 0, lo_len = 0, lo_min = 1000000;
  int cs_rises = 0, cs_rise_sk_hi = 0, last_bits = 0, last_prog_bits = 0;

  assign mdo = stuck ? 1'b0 : (!cs ? 1'b0 : (m_rd ? m_q : (m_busy > 0 ? 1'b0 : 1'b1)));

  initial begin
    for (int i = 0; i < NW; i++) mem[i] = '1;
    m_we = 0; stuck = 0; m_busy = 0; m_start = 0; m_rd = 0; m_n = 0;
    m_sel_p = 0; m_sk_p = 0; m_q = 0; m_sr = '0;
  end

  always @(posedge clk) begin
    if (m_busy > 0) m_busy--;
    if (sk) hi_len++;
    else if (m_sk_p) begin
      if (hi_len < hi_min) hi_min = hi_len;
      if (hi_len > hi_max) hi_max = hi_len;
      hi_len = 0;
    end
    if (!cs) lo_len++;
    if (cs && !m_sel_p) begin
      cs_rises++;
      if (sk) cs_rise_sk_hi++;
      if (cs_rises > 1 && lo_len < lo_min) lo_min = lo_len;
      lo_len = 0;
    end
    if (cs && sk && !m_sk_p) begin
      if (!m_start) begin
        if (di) begin m_start = 1; m_n = 1; m_sr = '0; end
      end else if (m_rd) begin
        m_q = mem[m_raddr][m_ridx];
        if (m_ridx == 0) begin m_ridx = DW - 1; m_raddr++; end
        else m_ridx--;
      end else begin
        m_n++;
        m_sr = {m_sr[62:0], di};
        if (m_n == 3 + AW && m_sr[AW+1:AW] == 2'b10) begin
          m_rd = 1; m_raddr = m_sr[AW-1:0]; m_ridx = DW - 1; m_q = 1'b0;
        end
      end
    end
    if (!cs && m_sel_p) begin
      if (m_start && !m_rd) begin
        last_bits = m_n;
        if (m_n == 3 + AW) begin
          eo = m_sr[AW+1:AW]; ea = m_sr[AW-1:0];
          if (eo == 2'b11 || (eo == 2'b00 && ea[AW-1:AW-2] == 2'b10)) last_prog_bits = m_n;
          if (eo == 2'b00 && ea[AW-1:AW-2] == 2'b11) m_we = 1;
          if (eo == 2'b00 && ea[AW-1:AW-2] == 2'b00) m_we = 0;
          if (m_we && eo == 2'b11) begin mem[ea] = '1; m_busy = BUSY; end
          if (m_we && eo == 2'b00 && ea[AW-1:AW-2] == 2'b10) begin
            for (int i = 0; i < NW; i++) mem[i] = '1;
            m_busy = BUSY;
          end
        end else if (m_n == 3 + AW + DW) begin
          eo = m_sr[DW+AW+1:DW+AW]; ea = m_sr[DW+AW-1:DW]; ed = m_sr[DW-1:0];
          if (eo == 2'b01 || (eo == 2'b00 && ea[AW-1:AW-2] == 2'b01)) last_prog_bits = m_n;
          if (m_we && eo == 2'b01) begin mem[ea] = ed; m_busy = BUSY; end
          if (m_we && eo == 2'b00 && ea[AW-1:AW-2] == 2'b01) begin
            for (int i = 0; i < NW; i++) mem[i] = ed;
            m_busy = BUSY;
          end
        end
      end
      m_start = 0; m_rd = 0; m_n = 0;
    end
    m_sel_p = cs; m_sk_p = sk;
  end

  // ---------------- output capture ----------------
  logic [DW-1:0] rd_buf [64];
  int rd_n = 0, done_cnt = 0;
  bit last_err;
  always @(posedge clk) begin
    if (rd_valid && rd_ready && rd_n < 64) begin rd_buf[rd_n] = rd_data; rd_n++; end
    if (done) begin done_cnt++; last_err = err; end
  end

  task automatic run_cmd(input logic [2:0] op, input logic [AW-1:0] a,
                         input logic [DW-1:0] d, input logic [3:0] n);
    int d0;
    d0 = done_cnt;
    @(negedge clk);
    cmd_valid = 1; cmd_op = op; cmd_addr = a; cmd_wdata = d; cmd_len = n;
    @(posedge clk);
    while (!cmd_ready) @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    while (done_cnt == d0) @(negedge clk);
  endtask

  // op code: 0 read, 1 write, 2 erase, 3 erase-all, 4 write-all, 5 enable, 6 disable
  // entry: {op, addr, wdata, expected read word}
  localparam logic [40:0] TBL [18] = '{
    {3'd5, 6'd0,  16'h0000, 16'h0000},
    {3'd1, 6'd5,  16'hA5C3, 16'h0000},
    {3'd0, 6'd5,  16'h0000, 16'hA5C3},
    {3'd1, 6'd6,  16'h1234, 16'h0000},
    {3'd0, 6'd6,  16'h0000, 16'hFFFF},
    {3'd5, 6'd0,  16'h0000, 16'h0000},
    {3'd1, 6'd6,  16'h1234, 16'h0000},
    {3'd0, 6'd6,  16'h0000, 16'h1234},
    {3'd5, 6'd0,  16'h0000, 16'h0000},
    {3'd2, 6'd5,  16'h0000, 16'h0000},
    {3'd0, 6'd5,  16'h0000, 16'hFFFF},
    {3'd5, 6'd0,  16'h0000, 16'h0000},
    {3'd1, 6'd63, 16'h8001, 16'h0000},
    {3'd0, 6'd63, 16'h0000, 16'h8001},
    {3'd5, 6'd0,  16'h0000, 16'h0000},
    {3'd6, 6'd0,  16'h0000, 16'h0000},
    {3'd1, 6'd7,  16'hBEEF, 16'h0000},
    {3'd0, 6'd7,  16'h0000, 16'hFFFF}
  };

  initial begin
    int rises0, n0;
    cmd_valid = 0; cmd_op = 0; cmd_addr = 0; cmd_wdata = 0; cmd_len = 0; rd_ready = 1;
    rst_n = 0;
    repeat (3) @(negedge clk);
    chk(!cs && !sk, "R11 bus idle in reset", {cs, sk}, 0);
    chk(cmd_ready && !rd_valid && !done, "R11 handshake in reset", {cmd_ready, rd_valid, done}, 3'b100);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(cmd_ready && !cs && !sk, "R11 after reset", {cmd_ready, cs, sk}, 3'b100);

    foreach (TBL[k]) begin
      logic [2:0] op;
      op = TBL[k][40:38];
      rises0 = cs_rises; n0 = rd_n;
      run_cmd(op, TBL[k][37:32], TBL[k][31:16], 4'd0);
      chk(!last_err, "R7 no timeout", last_err, 0);
      if (op == 3'd0) begin
        chk(rd_n == n0 + 1, "R3 one word", rd_n - n0, 1);
        chk(rd_buf[n0] == TBL[k][15:0], "R3 read word", rd_buf[n0], TBL[k][15:0]);
        chk(cs_rises - rises0 == 1, "R1 read single select", cs_rises - rises0, 1);
      end else if (op >= 3'd5) begin
        chk(last_bits == 3 + AW, "R10 enable/disable frame length", last_bits, 3 + AW);
        chk(cs_rises - rises0 == 1, "R10 no poll", cs_rises - rises0, 1);
      end else begin
        chk(last_prog_bits == ((op == 3'd1) ? 3 + AW + DW : 3 + AW), "R5 program clock count",
            last_prog_bits, (op == 3'd1) ? 3 + AW + DW : 3 + AW);
        chk(m_busy == 0, "R6 done after ready", m_busy, 0);
        chk(cs_rises - rises0 == 3, "R6 frame, poll, lock", cs_rises - rises0, 3);
        chk(last_bits == 3 + AW && !m_we, "R9 lock frame last", last_bits, 3 + AW);
      end
    end

    // multi-word read with rollover past the top address
    run_cmd(3'd5, 0, 0, 0);
    run_cmd(3'd1, 6'd62, 16'h0F0F, 0);
    n0 = rd_n;
    run_cmd(3'd0, 6'd62, 0, 4'd2);
    chk(rd_n == n0 + 3, "R3 word count", rd_n - n0, 3);
    chk(rd_buf[n0] == 16'h0F0F, "R3 word 0", rd_buf[n0], 16'h0F0F);
    chk(rd_buf[n0+1] == 16'h8001, "R3 word 1", rd_buf[n0+1], 16'h8001);
    chk(rd_buf[n0+2] == 16'hFFFF, "R3 rollover word", rd_buf[n0+2], 16'hFFFF);

    // read backpressure
    rd_ready = 0;
    n0 = rd_n;
    fork
      run_cmd(3'd0, 6'd6, 0, 4'd1);
      begin
        @(negedge clk);
        while (!rd_valid) @(negedge clk);
        repeat (20) @(negedge clk);
        chk(rd_valid && !sk, "R4 stalled clock", {rd_valid, sk}, 2'b10);
        chk(rd_data == 16'h1234, "R4 held data", rd_data, 16'h1234);
        rd_ready = 1;
      end
    join
    chk(rd_n == n0 + 2 && rd_buf[n0+1] == 16'hFFFF, "R4 second word", rd_buf[n0+1], 16'hFFFF);

    // busy handshake, then write-all
    fork
      run_cmd(3'd5, 0, 0, 0);
      begin
        @(negedge clk);
        while (!cs) @(negedge clk);
        repeat (5) @(negedge clk);
        chk(!cmd_ready, "R8 not ready in flight", cmd_ready, 0);
      end
    join
    run_cmd(3'd4, 0, 16'h3C3C, 0);
    chk(last_prog_bits == 3 + AW + DW, "R5 write-all clock count", last_prog_bits, 3 + AW + DW);
    n0 = rd_n;
    run_cmd(3'd0, 6'd10, 0, 0);
    chk(rd_buf[n0] == 16'h3C3C, "R5 write-all data", rd_buf[n0], 16'h3C3C);

    // erase-all
    run_cmd(3'd5, 0, 0, 0);
    run_cmd(3'd3, 0, 0, 0);
    chk(last_prog_bits == 3 + AW, "R5 erase-all clock count", last_prog_bits, 3 + AW);
    n0 = rd_n;
    run_cmd(3'd0, 6'd62, 0, 0);
    chk(rd_buf[n0] == 16'hFFFF, "R5 erase-all data", rd_buf[n0], 16'hFFFF);

    // poll timeout
    run_cmd(3'd5, 0, 0, 0);
    stuck = 1;
    rises0 = cs_rises;
    run_cmd(3'd1, 6'd1, 16'h5555, 0);
    chk(last_err, "R7 timeout flagged", last_err, 1);
    chk(cs_rises - rises0 == 2, "R7 no lock after timeout", cs_rises - rises0, 2);
    stuck = 0;

    chk(hi_min == DIV && hi_max == DIV, "R2 clock high time", {hi_min[15:0], hi_max[15:0]}, {16'(DIV), 16'(DIV)});
    chk(cs_rise_sk_hi == 0, "R1 select with clock low", cs_rise_sk_hi, 0);
    chk(lo_min >= GAP, "R6 guard interval", lo_min, GAP);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog act=%0h exp=%0h", 1, 0);
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

endmodule